// File: doc/BRIEF.md
# Synchronized Event Clear Gate

This block takes an asynchronous front-panel clear request and turns it into a one-cycle abort pulse for the event currently being processed. The pulse is produced only while a clear window is open. A rising edge on the common stop input opens the window, and the window then stays open for a programmed number of system-clock periods. An interval of zero means no window is ever opened, so every clear request is ignored.

Both asynchronous inputs first pass through a flop-chain synchronizer. A rising-edge detector follows each synchronizer. Because the inputs are resampled on the system clock, acceptance carries up to one clock period of jitter. A clear edge that arrives in the same cycle as a stop edge belongs to no window and is dropped. A window honours at most one clear. A further stop edge while the window is open restarts the interval with the current setting and re-arms the window for one more clear.

The block has no data stream, so there is no valid/ready handshake. Every pin is a plain level or pulse. The abort pulse is not held waiting for an acknowledge; the downstream logic samples it in the single cycle it is high.

Top module: `evclr_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `abort_o` and `win_open_o` are low.
- R2: If `stop_i` rises and is sampled at clock edge k, `win_open_o` is high after edges k+2 through k+N+1 and low after edge k+N+2. N is the value of `interval_i`, sampled when the window loads.
- R3: An interval of zero opens no window, and no clear request in that period produces an abort.
- R4: A rising `clear_i` first sampled at edge k+d, with 1 <= d <= N, produces `abort_o` high for exactly the one cycle after edge k+d+2.
- R5: A clear edge with d = 0 or d > N produces no abort.
- R6: At most one abort is produced per window. Later clear edges inside the same window are ignored.
- R7: A stop edge while the window is open reloads the interval from that stop and re-arms the window, so one more clear is accepted until the new interval ends.
- R8: `abort_o` lasts one cycle however long `clear_i` is held high.
- R9: Only a low-to-high transition of `clear_i` counts. A clear that is already high when the window opens produces no abort.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Common stop, asynchronous; a rising edge opens the window |
| clear_i | input | 1 | Front-panel clear request, asynchronous |
| interval_i | input | IVL_W | Window length in clock periods; sampled when the window loads |
| abort_o | output | 1 | One-cycle event-abort pulse |
| win_open_o | output | 1 | High while the clear window is open |

## Verification
The hardest case to reach from the ports is a second stop edge while a window is still open, followed by a clear that lands after the first window would have ended but inside the reloaded one. The same window must also already have spent its clear. The stimulus accepts a clear early in a first window and restarts the stop six cycles later. It then checks that the window is still open past the original end and places a clear there, which must be accepted. The timing of the synchronized edges is modelled in the bench as a cycle offset d from the stop edge. This offset lets the bench place clears exactly at d = 0, d = 1, d = N and d = N+1.

// File: rtl/evclr_pkg.sv
package evclr_pkg;
  // smallest chain that resolves metastability before edge detection
  localparam int unsigned SYNC_MIN = 2;

  // synchronized rising edges of the two asynchronous inputs
  typedef struct packed {
    logic stop;
    logic clr;
  } evclr_evt_t;
endpackage

// File: rtl/evclr_sync.sv
// Flop-chain synchronizer with rising-edge detection on the resolved level.
module evclr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  localparam int unsigned NST = (STAGES < evclr_pkg::SYNC_MIN) ? evclr_pkg::SYNC_MIN : STAGES;

  logic [NST-1:0] chain_q;
  logic           prev_q;

  generate
    for (genvar g = 0; g < NST; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[NST-1];
  end

  assign rise_o = chain_q[NST-1] & ~prev_q;
endmodule

// File: rtl/evclr_win_timer.sv
// Down-counter holding the remaining window length; reloads on every stop.
module evclr_win_timer #(
  parameter int unsigned IVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [IVL_W-1:0] init_i,
  output logic             open_o
);
  logic [IVL_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remain_q <= '0;
    else if (load_i)           remain_q <= init_i;
    else if (remain_q != '0)   remain_q <= remain_q - 1'b1;
  end

  assign open_o = (remain_q != '0);
endmodule

// File: rtl/evclr_accept.sv
// Decides whether a synchronized clear edge becomes an abort pulse.
module evclr_accept (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_rise_i,
  input  logic stop_rise_i,
  input  logic open_i,
  output logic abort_o
);
  logic spent_q;
  logic take;

  // a stop in the same cycle starts a fresh window and wins over the clear
  assign take = clr_rise_i & open_i & ~spent_q & ~stop_rise_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spent_q <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      abort_o <= take;
      if (stop_rise_i) spent_q <= 1'b0;
      else if (take)   spent_q <= 1'b1;
    end
  end
endmodule

// File: rtl/evclr_gate.sv
module evclr_gate #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IVL_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_i,
  input  logic             clear_i,
  input  logic [IVL_W-1:0] interval_i,
  output logic             abort_o,
  output logic             win_open_o
);
  import evclr_pkg::*;

  evclr_evt_t evt;
  logic       stop_rise;
  logic       clr_rise;

  evclr_sync #(.STAGES(SYNC_STAGES)) u_stop_sync (
    .clk(clk), .rst_n(rst_n), .async_i(stop_i), .rise_o(evt.stop)
  );

  evclr_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk(clk), .rst_n(rst_n), .async_i(clear_i), .rise_o(evt.clr)
  );

  assign stop_rise = evt.stop;
  assign clr_rise  = evt.clr;

  evclr_win_timer #(.IVL_W(IVL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(stop_rise), .init_i(interval_i),
    .open_o(win_open_o)
  );

  evclr_accept u_accept (
    .clk(clk), .rst_n(rst_n), .clr_rise_i(clr_rise), .stop_rise_i(stop_rise),
    .open_i(win_open_o), .abort_o(abort_o)
  );
endmodule

// File: rtl/evclr_gate_chk.sv
module evclr_gate_chk #(
  parameter int unsigned IVL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_rise,
  input logic             clr_rise,
  input logic [IVL_W-1:0] interval,
  input logic             win_open,
  input logic             abort
);
  logic [1:0] aborts_in_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    aborts_in_win <= '0;
    else if (stop_rise)                            aborts_in_win <= '0;
    else if (abort && aborts_in_win != 2'd3)       aborts_in_win <= aborts_in_win + 1'b1;
  end

  // R8
  abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);

  // R5
  abort_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> ($past(win_open) && $past(clr_rise)));

  // R2
  open_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(stop_rise));

  // R3
  zero_ivl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_rise && interval == '0) |=> !win_open);

  // R6
  one_per_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aborts_in_win <= 2'd1);
endmodule

bind evclr_gate evclr_gate_chk #(.IVL_W(IVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_rise(stop_rise), .clr_rise(clr_rise),
  .interval(interval_i), .win_open(win_open_o), .abort(abort_o)
);

// File: tb/evclr_gate_tb_top.sv
`timescale 1ns/1ps
module evclr_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_i = 1'b0;
  logic       clear_i = 1'b0;
  logic [7:0] interval_i = '0;
  logic       abort_o;
  logic       win_open_o;

  evclr_gate #(.SYNC_STAGES(2), .IVL_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .clear_i(clear_i),
    .interval_i(interval_i), .abort_o(abort_o), .win_open_o(win_open_o)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int    exp_q[$];
  string tag_q[$];
  int stop_k = 0;
  int cur_ivl = 0;
  bit spent = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: every abort must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && abort_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5/R6 unexpected abort", cyc, -1);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(e == cyc, t, cyc, e);
      end
    end
  end

  task automatic go_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic fire_stop(int ivl, bit with_clr);
    stop_k = cyc + 1;
    interval_i = 8'(ivl);
    cur_ivl = ivl;
    spent = 0;
    stop_i = 1'b1;
    if (with_clr) clear_i = 1'b1;   // d = 0: never accepted
    @(negedge clk);
    stop_i = 1'b0;
    clear_i = 1'b0;
  endtask

  task automatic fire_clear(int d, int hold, string tag);
    int m;
    go_to(stop_k + d - 1);
    m = cyc + 1;
    if (d >= 1 && d <= cur_ivl && !spent) begin
      exp_q.push_back(m + 2);
      tag_q.push_back(tag);
      spent = 1;
    end
    clear_i = 1'b1;
    repeat (hold) @(negedge clk);
    clear_i = 1'b0;
  endtask

  task automatic settle(string req);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(abort_o == 1'b0, "R1 abort in reset", abort_o, 0);
    chk(win_open_o == 1'b0, "R1 window in reset", win_open_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(abort_o == 1'b0, "R1 abort after reset", abort_o, 0);
    chk(win_open_o == 1'b0, "R1 window after reset", win_open_o, 0);

    // R2: window length for N = 5
    fire_stop(5, 1'b0);
    go_to(stop_k + 1);
    chk(win_open_o == 1'b0, "R2 before open", win_open_o, 0);
    for (int j = 2; j <= 6; j++) begin
      go_to(stop_k + j);
      chk(win_open_o == 1'b1, "R2 open", win_open_o, 1);
    end
    go_to(stop_k + 7);
    chk(win_open_o == 1'b0, "R2 closed", win_open_o, 0);
    settle("R2 idle");

    // R4 + R6: accepted clear, then a second one in the same window ignored
    fire_stop(6, 1'b0);
    fire_clear(3, 1, "R4 accept d=3");
    fire_clear(5, 1, "R6 second clear");
    settle("R6 one per window");

    // R4 boundary d = 1
    fire_stop(4, 1'b0);
    fire_clear(1, 1, "R4 accept d=1");
    settle("R4 d=1");

    // R4 boundary d = N
    fire_stop(4, 1'b0);
    fire_clear(4, 1, "R4 accept d=N");
    settle("R4 d=N");

    // R5: d = 0 and d = N+1 rejected
    fire_stop(4, 1'b1);
    fire_clear(5, 1, "R5 d=N+1");
    settle("R5 outside window");

    // R3: zero interval
    fire_stop(0, 1'b0);
    go_to(stop_k + 3);
    chk(win_open_o == 1'b0, "R3 no window", win_open_o, 0);
    fire_clear(4, 1, "R3 clear ignored");
    settle("R3 zero interval");

    // R8: long clear gives one pulse
    fire_stop(12, 1'b0);
    fire_clear(2, 8, "R8 long clear");
    settle("R8 single pulse");

    // R9: clear already high before the window opens
    clear_i = 1'b1;
    repeat (3) @(negedge clk);
    fire_stop(6, 1'b0);
    clear_i = 1'b1;
    repeat (10) @(negedge clk);
    clear_i = 1'b0;
    settle("R9 level not edge");

    // R7: reload while open re-arms
    fire_stop(10, 1'b0);
    fire_clear(2, 1, "R7 first window");
    go_to(stop_k + 5);
    fire_stop(10, 1'b0);
    go_to(stop_k + 7);
    chk(win_open_o == 1'b1, "R7 reloaded window open", win_open_o, 1);
    fire_clear(9, 1, "R7 re-armed clear");
    settle("R7 reload");

    $display("  test done: total=%0d bad=%0d", total, bad);
    done = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule